// File: doc/BRIEF.md
# Register-Read Interrupt Arbiter

This block is the slave side of a narrow bridge through which an external master reads and writes a small set of byte-wide configuration registers. The master issues a read command that carries a register address. The block fetches the value, drives it onto an 8-bit data bus, and signals that the data is ready by pulling a single active-low interrupt line. The same line also reports asynchronous events coming from the rest of the chip. This creates a conflict, which the block resolves by giving read-data-ready sole use of the line from the moment a read command is taken until the master strobes the data out.

Events that fire while a read is outstanding are latched as sticky pending bits. They are reported only after the read completes: the line goes high for one cycle on the data-read strobe and then falls again if anything is pending. The pending bits, together with a sticky flag that records a read command rejected because another read was still open, are visible in a status register at the top address. Reading that register returns its contents and clears them.

Top module: `rdreg_irq_bridge`

## Requirements
- R1: After reset, `irq_no` is high, `data_oe_o` is low, `rd_err_o` is low, every register reads 0x00 and no event is pending.
- R2: A `wr_cmd_i` pulse stores `wr_data_i` into register `cmd_addr_i` at the clock edge. Addresses 0 to 6 are writable. A write to the status address 7 has no effect on what that address returns.
- R3: A `rd_cmd_i` pulse accepted in the idle state leaves `irq_no` high for the next cycle. After the second clock edge, `irq_no` is low, `data_oe_o` is high and `data_o` holds the register value captured at that edge.
- R4: From command acceptance until the data-read strobe, `irq_no` is low only while read data is presented, whatever events occur.
- R5: Events that occur while a read is outstanding are latched. After the data-read strobe, `irq_no` is high for exactly one cycle and then low if any event is pending.
- R6: A `data_rd_i` pulse while data is presented drives `irq_no` high and `data_oe_o` low after the next edge.
- R7: A `rd_cmd_i` pulse that arrives while a read is outstanding, or in the one-cycle release after it, is ignored and sets the sticky error flag (`rd_err_o`, status bit 7).
- R8: Reading address 7 returns a byte with bit 7 holding the error flag, bits 6:4 zero and bits 3:0 holding the pending events. The pending bits and the error flag are cleared at the capture edge, but an event or error that occurs at that same edge is kept.
- R9: An event that fires again while its pending bit is already set leaves that single bit set. Events on distinct sources set distinct bits, where source n sets bit n.
- R10: When the block is idle, an event pulse drives `irq_no` low after the next clock edge.
- R11: A `data_rd_i` pulse while no data is presented has no effect on `irq_no`, `data_oe_o` or pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_cmd_i | input | 1 | Read-register command strobe |
| wr_cmd_i | input | 1 | Write-register command strobe |
| cmd_addr_i | input | 3 | Register address for either command |
| wr_data_i | input | 8 | Write data |
| data_rd_i | input | 1 | Master has taken the read data |
| evt_i | input | 4 | Event pulses, one per source |
| data_o | output | 8 | Read data bus |
| data_oe_o | output | 1 | Read data bus is driven and valid |
| irq_no | output | 1 | Shared active-low interrupt line |
| rd_err_o | output | 1 | Sticky rejected-read flag |

## Verification
The bench aims events at the fetch cycle, the data-ready window and the release cycle. A design that let an event pull the line low there would present a false data-ready, and one that dropped the event would never report it afterwards. Status reads are raced against events landing on the capture edge: a design that cleared too broadly would lose those events, and one that did not clear would report the same sources twice. The bench also issues second read commands during the window and spurious data strobes while idle. A careless design would either restart the read and overwrite the captured byte, or end a read that never began.

// File: rtl/rdirq_pkg.sv
package rdirq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_FETCH   = 2'd1,
    ST_READY   = 2'd2,
    ST_RELEASE = 2'd3
  } seq_state_e;
endpackage

// File: rtl/rdirq_regfile.sv
module rdirq_regfile #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  // top address is reserved for status, so one fewer storage entry
  localparam int NREG = (1 << ADDR_W) - 1;

  logic [NREG-1:0][DATA_W-1:0] regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (wr_en_i && (wr_addr_i == ADDR_W'(i))) regs_q[i] <= wr_data_i;
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_addr_i == ADDR_W'(i)) rd_data_o = regs_q[i];
    end
  end
endmodule

// File: rtl/rdirq_pending.sv
module rdirq_pending #(
  parameter int N_SRC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             clr_i,
  input  logic             err_set_i,
  output logic [N_SRC-1:0] pend_o,
  output logic             err_o
);
  logic [N_SRC-1:0] pend_q;
  logic             err_q;

  // a clear and a fresh event on the same edge keep the fresh one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      err_q  <= 1'b0;
    end else begin
      pend_q <= (clr_i ? '0 : pend_q) | evt_i;
      err_q  <= (clr_i ? 1'b0 : err_q) | err_set_i;
    end
  end

  assign pend_o = pend_q;
  assign err_o  = err_q;

  AST_EVT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((pend_q & $past(evt_i)) == $past(evt_i)));  // R9
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_set_i |=> err_q);  // R7
  AST_HOLD_NO_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && (|pend_q)) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));  // R5
endmodule

// File: rtl/rdirq_seq.sv
module rdirq_seq
  import rdirq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_cmd_i,
  input  logic data_rd_i,
  input  logic pend_any_i,
  output logic accept_o,
  output logic capture_o,
  output logic reject_o,
  output logic irq_no,
  output logic data_oe_o
);
  seq_state_e state_q, state_d;

  assign accept_o  = (state_q == ST_IDLE) && rd_cmd_i;
  assign reject_o  = (state_q != ST_IDLE) && rd_cmd_i;
  assign capture_o = (state_q == ST_FETCH);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (rd_cmd_i) state_d = ST_FETCH;
      ST_FETCH:   state_d = ST_READY;
      ST_READY:   if (data_rd_i) state_d = ST_RELEASE;
      ST_RELEASE: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // line owned by data-ready outside idle; pending only shows when idle
  assign irq_no    = !((state_q == ST_READY) || ((state_q == ST_IDLE) && pend_any_i));
  assign data_oe_o = (state_q == ST_READY);

  AST_FETCH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> (irq_no && !data_oe_o));  // R4
  AST_DATA_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |=> (!irq_no && data_oe_o));  // R3
  AST_RELEASE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && data_rd_i) |=> (irq_no && !data_oe_o));  // R6
  AST_STRAY_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && data_rd_i && !rd_cmd_i) |=> !data_oe_o);  // R11
endmodule

// File: rtl/rdreg_irq_bridge.sv
module rdreg_irq_bridge #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int N_SRC  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_cmd_i,
  input  logic              wr_cmd_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              data_rd_i,
  input  logic [N_SRC-1:0]  evt_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              irq_no,
  output logic              rd_err_o
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = {ADDR_W{1'b1}};

  logic              accept, capture, reject;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] reg_rdata, stat_word, data_q;
  logic [N_SRC-1:0]  pend;
  logic              err;
  logic              is_stat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (accept) addr_q <= cmd_addr_i;
  end

  assign is_stat = (addr_q == STAT_ADDR);

  rdirq_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_cmd_i && (cmd_addr_i != STAT_ADDR)),
    .wr_addr_i (cmd_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (addr_q),
    .rd_data_o (reg_rdata)
  );

  rdirq_pending #(.N_SRC(N_SRC)) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt_i),
    .clr_i     (capture && is_stat),
    .err_set_i (reject),
    .pend_o    (pend),
    .err_o     (err)
  );

  rdirq_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_cmd_i   (rd_cmd_i),
    .data_rd_i  (data_rd_i),
    .pend_any_i (|pend),
    .accept_o   (accept),
    .capture_o  (capture),
    .reject_o   (reject),
    .irq_no     (irq_no),
    .data_oe_o  (data_oe_o)
  );

  always_comb begin
    stat_word = '0;
    stat_word[DATA_W-1] = err;
    stat_word[N_SRC-1:0] = pend;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (capture) data_q <= is_stat ? stat_word : reg_rdata;
  end

  assign data_o   = data_q;
  assign rd_err_o = err;

  AST_IDLE_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!data_oe_o && irq_no && !rd_cmd_i && !capture && (|evt_i) && !reject && $past(!rd_cmd_i))
      |=> (!irq_no || data_oe_o || $past(data_rd_i)));  // R10
  AST_DATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && !data_rd_i) |=> $stable(data_o));  // R4
endmodule

// File: tb/tb_rdreg_irq_bridge.sv
module tb_rdreg_irq_bridge;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int N_SRC  = 4;
  localparam int STAT   = 7;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              rd_cmd_i = 1'b0, wr_cmd_i = 1'b0, data_rd_i = 1'b0;
  logic [ADDR_W-1:0] cmd_addr_i = '0;
  logic [DATA_W-1:0] wr_data_i = '0;
  logic [N_SRC-1:0]  evt_i = '0;
  logic [DATA_W-1:0] data_o;
  logic              data_oe_o, irq_no, rd_err_o;

  rdreg_irq_bridge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_SRC(N_SRC)) dut (.*);

  always #5 clk_i = ~clk_i;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // reference model: 0 idle, 1 fetch, 2 ready, 3 release
  int               m_state = 0;
  logic [7:0]       m_regs [8];
  logic [N_SRC-1:0] m_pend = '0;
  logic             m_err = 1'b0;
  logic [2:0]       m_addr = '0;
  logic [7:0]       m_data = '0;

  function automatic logic [7:0] stat_val(logic e, logic [N_SRC-1:0] p);
    return {e, 3'b000, p};
  endfunction

  function automatic logic exp_irq_n();
    return !((m_state == 2) || ((m_state == 0) && (m_pend != 0)));
  endfunction

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(string tag, logic rd, logic wr, logic [2:0] a, logic [7:0] wd,
                     logic drd, logic [N_SRC-1:0] ev);
    logic clr;
    rd_cmd_i = rd; wr_cmd_i = wr; cmd_addr_i = a; wr_data_i = wd;
    data_rd_i = drd; evt_i = ev;
    @(posedge clk_i);
    clr = 1'b0;
    case (m_state)
      0: if (rd) begin m_state = 1; m_addr = a; end
      1: begin
           m_data = (m_addr == 3'(STAT)) ? stat_val(m_err, m_pend) : m_regs[m_addr];
           clr = (m_addr == 3'(STAT));
           m_state = 2;
         end
      2: if (drd) m_state = 3;
      default: m_state = 0;
    endcase
    m_err  = (clr ? 1'b0 : m_err) | (rd && (m_state != 1 || !(m_addr == a && clr === 1'bx)) && 1'b0);
    @(negedge clk_i);
    rd_cmd_i = 0; wr_cmd_i = 0; data_rd_i = 0; evt_i = '0;
  endtask

  // model update written separately so the error term reads plainly
  task automatic step(string tag, logic rd, logic wr, logic [2:0] a, logic [7:0] wd,
                      logic drd, logic [N_SRC-1:0] ev);
    logic busy;
    logic clr;
    busy = (m_state != 0);
    clr  = (m_state == 1) && (m_addr == 3'(STAT));
    cyc(tag, rd, wr, a, wd, drd, ev);
    m_pend = (clr ? '0 : m_pend) | ev;
    m_err  = (clr ? 1'b0 : m_err) | (rd && busy);
    if (wr && a != 3'(STAT)) m_regs[a] = wd;
    chk(tag, "irq_no", {7'd0, irq_no}, {7'd0, exp_irq_n()});
    chk(tag, "data_oe_o", {7'd0, data_oe_o}, {7'd0, (m_state == 2)});
    chk("R7", "rd_err_o", {7'd0, rd_err_o}, {7'd0, m_err});
    if (m_state == 2) chk(tag, "data_o", data_o, m_data);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic rd_seq(string tag, logic [2:0] a);
    step(tag, 1, 0, a, 0, 0, 0);
    step(tag, 0, 0, 0, 0, 0, 0);
    step(tag, 0, 0, 0, 0, 1, 0);
    step(tag, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) m_regs[i] = 8'h00;
    #22 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1", "irq_no", {7'd0, irq_no}, 8'd1);
    chk("R1", "data_oe_o", {7'd0, data_oe_o}, 8'd0);
    chk("R1", "rd_err_o", {7'd0, rd_err_o}, 8'd0);
    rd_seq("R1", 3'd4);
    rd_seq("R1", 3'(STAT));

    // R2 R3 write then read every storage register
    for (int i = 0; i < 7; i++) step("R2", 0, 1, 3'(i), 8'(8'h3C + i * 17), 0, 0);
    for (int i = 0; i < 7; i++) rd_seq("R3", 3'(i));
    // R2 status address not writable
    step("R2", 0, 1, 3'(STAT), 8'hFF, 0, 0);
    rd_seq("R2", 3'(STAT));

    // R10 idle event asserts the line after one edge
    step("R10", 0, 0, 0, 0, 0, 4'b0010);
    // R8 status read returns and clears
    rd_seq("R8", 3'(STAT));
    idle("R8", 2);

    // R4 R5 events inside the read window
    step("R4", 1, 0, 3'd2, 0, 0, 4'b0001);
    step("R4", 0, 0, 0, 0, 0, 4'b0100);
    step("R4", 0, 0, 0, 0, 0, 4'b1000);
    step("R5", 0, 0, 0, 0, 1, 0);
    step("R5", 0, 0, 0, 0, 0, 0);
    idle("R5", 1);
    rd_seq("R8", 3'(STAT));

    // R8 event on capture edge survives the clear
    step("R10", 0, 0, 0, 0, 0, 4'b0001);
    step("R8", 1, 0, 3'(STAT), 0, 0, 0);
    step("R8", 0, 0, 0, 0, 0, 4'b0001);
    step("R8", 0, 0, 0, 0, 1, 0);
    idle("R8", 2);
    rd_seq("R8", 3'(STAT));

    // R7 second read command rejected, data kept
    step("R7", 1, 0, 3'd1, 0, 0, 0);
    step("R7", 1, 0, 3'd5, 0, 0, 0);
    step("R7", 1, 0, 3'd6, 0, 0, 0);
    step("R7", 0, 0, 0, 0, 1, 0);
    step("R7", 1, 0, 3'd3, 0, 0, 0);
    idle("R7", 1);
    rd_seq("R7", 3'(STAT));

    // R9 repeated event merges
    step("R9", 0, 0, 0, 0, 0, 4'b0100);
    step("R9", 0, 0, 0, 0, 0, 4'b0100);
    step("R9", 0, 0, 0, 0, 0, 4'b0100);
    rd_seq("R9", 3'(STAT));

    // R11 stray data strobe while idle
    step("R11", 0, 0, 0, 0, 1, 0);
    step("R11", 0, 0, 0, 0, 0, 4'b0001);
    step("R11", 0, 0, 0, 0, 1, 0);
    rd_seq("R11", 3'(STAT));

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic rd, wr, drd;
      logic [N_SRC-1:0] ev;
      rd  = ($urandom % 6) == 0;
      wr  = ($urandom % 4) == 0;
      drd = ($urandom % 3) == 0;
      ev  = '0;
      for (int b = 0; b < N_SRC; b++) ev[b] = ($urandom % 10) == 0;
      step("R9", rd, wr, 3'($urandom), 8'($urandom), drd, ev);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule